// File: doc/BRIEF.md
# Two-Section Decade Ripple Counter

This block is a four-bit counter made of two separate sections. The first section divides by two and drives bit 0 of the output. The second section divides by five and drives bits 3 to 1. Each section has its own count input and steps on a falling edge of that input. Either section can run on its own. The two can also be chained outside the block to count in BCD order (bit 0 drives the second section's input) or in bi-quinary order (bit 3 drives the first section's input).

The count inputs are treated as slow external signals. Each one passes through a synchronizer clocked by a fast system clock, and an edge detector turns each high-to-low change into a one-cycle advance pulse.

Two gated controls act on both sections at once. One clears the count, and it needs both of its inputs high. The other forces the count to decimal nine, and it also needs both of its inputs high. Both controls are registered on the system clock and are independent of the count inputs. The block has no data stream, so every pin is plain control or status.

Top module: `twosec_decade_counter`

## Requirements
- R1: While `rst_n` is low, `out_q` reads 0.
- R2: Each falling edge on `tick_a` inverts `out_q[0]`. A rising edge on `tick_a` changes nothing.
- R3: Each falling edge on `tick_b` steps `out_q[3:1]` through 0,1,2,3,4 and then back to 0. From any code above 4, the next step goes to 0.
- R4: After a count input goes low, the count changes at the third rising system-clock edge that samples the new level, and not before. With no advance pulse, clear or preset, `out_q` holds its value.
- R5: With `out_q[0]` wired to `tick_b`, falling edges on `tick_a` give the BCD sequence 0..9 on `out_q`, and 9 wraps to 0.
- R6: With `out_q[3]` wired to `tick_a`, falling edges on `tick_b` give the sequence 0,2,4,6,8,1,3,5,7,9 on `out_q`. Here `out_q[0]` is a square wave at one tenth of the input rate.
- R7: When `clr_a` and `clr_b` are both high, `out_q` becomes 0 at the next system-clock edge. Either input alone has no effect.
- R8: When `nine_a` and `nine_b` are both high, `out_q` becomes 9 (binary 1001) at the next system-clock edge. Either input alone has no effect.
- R9: When clear and preset are both active, preset wins and `out_q` is 9.
- R10: While clear or preset is active, falling edges on the count inputs are dropped. After release, the count keeps the forced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count input of the divide-by-two section |
| tick_b | input | 1 | Count input of the divide-by-five section |
| clr_a | input | 1 | Clear gate input, first leg |
| clr_b | input | 1 | Clear gate input, second leg |
| nine_a | input | 1 | Preset-to-nine gate input, first leg |
| nine_b | input | 1 | Preset-to-nine gate input, second leg |
| out_q | output | 4 | Count; bit 0 from the divide-by-two section, bits 3..1 from the divide-by-five section |

## Verification
The assertions assume that each count input holds every level for longer than the synchronizer depth plus one system clock, so every falling edge turns into exactly one advance pulse. They also assume that the clear and preset legs are synchronous to the system clock. The stimulus meets both assumptions:
- Every count level is held for eight system clocks, which also covers the extra synchronizer delay in the chained wirings.
- Every control input changes at a falling clock edge.
- The chaining selection changes only while clear is held, so the edge that the switch creates is discarded.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int CNT_W  = 4;
  localparam int QUIN_W = CNT_W - 1;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [QUIN_W-1:0] quin_t;
  localparam quin_t QUIN_LAST = quin_t'(4);
  localparam cnt_t  CNT_NINE  = cnt_t'(9);
endpackage

// File: rtl/dcnt_fall_detect.sv
module dcnt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];
  end

  assign fall = prev_q & ~sync_q[TOP];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R4
endmodule

// File: rtl/dcnt_div2.sv
module dcnt_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
    else if (adv) q <= ~q;
  end

  AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !set) |=> (q != $past(q))); // R2
  AST_DIV2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr && !set) |=> $stable(q)); // R4
endmodule

// File: rtl/dcnt_div5.sv
module dcnt_div5
  import dcnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  clr,
  input  logic  set,
  output quin_t q
);
  quin_t step_nxt;

  always_comb begin
    if (q >= QUIN_LAST) step_nxt = '0;
    else                step_nxt = q + quin_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (set) q <= QUIN_LAST;
    else if (clr) q <= '0;
    else if (adv) q <= step_nxt;
  end

  AST_DIV5_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    q <= QUIN_LAST); // R3
  AST_DIV5_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !set && q == QUIN_LAST) |=> (q == '0)); // R3
  AST_DIV5_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr && !set) |=> $stable(q)); // R4
endmodule

// File: rtl/twosec_decade_counter.sv
module twosec_decade_counter
  import dcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       nine_a,
  input  logic       nine_b,
  output logic [3:0] out_q
);
  logic  fall_a, fall_b;
  logic  clr_hit, set_hit;
  logic  half_q;
  quin_t quin_q;

  assign clr_hit = clr_a & clr_b;
  assign set_hit = nine_a & nine_b;

  dcnt_fall_detect #(.STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .rst_n(rst_n), .din(tick_a), .fall(fall_a));
  dcnt_fall_detect #(.STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .rst_n(rst_n), .din(tick_b), .fall(fall_b));

  dcnt_div2 u_half (
    .clk(clk), .rst_n(rst_n), .adv(fall_a), .clr(clr_hit), .set(set_hit),
    .q(half_q));
  dcnt_div5 u_quin (
    .clk(clk), .rst_n(rst_n), .adv(fall_b), .clr(clr_hit), .set(set_hit),
    .q(quin_q));

  assign out_q = {quin_q, half_q};

  AST_PRESET_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> (out_q == CNT_NINE)); // R8
  AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && clr_hit) |=> (out_q == CNT_NINE)); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_hit) |=> (out_q == '0)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_a && !fall_b && !clr_hit && !set_hit) |=> $stable(out_q)); // R10
endmodule

// File: tb/twosec_decade_counter_test.sv
module twosec_decade_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_a = 1'b1, tb_b = 1'b1;
  logic       chain_bcd = 1'b0, chain_bq = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [3:0] out_q;
  logic       tick_a_w, tick_b_w;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tick_a_w = chain_bq  ? out_q[3] : tb_a;
  assign tick_b_w = chain_bcd ? out_q[0] : tb_b;

  twosec_decade_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a_w), .tick_b(tick_b_w),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
    .out_q(out_q));

  task automatic check(input logic [3:0] exp, input string req);
    n_cmp++;
    if (out_q !== exp) begin
      n_bad++;
      $display("FAIL %s: out_q=%0d expected %0d", req, out_q, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_a();
    @(negedge clk) tb_a = 1'b0;
    wait_cyc(SETTLE);
    tb_a = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic fall_b();
    @(negedge clk) tb_b = 1'b0;
    wait_cyc(SETTLE);
    tb_b = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic set_mode(input logic bcd, input logic bq);
    @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
    wait_cyc(2);
    chain_bcd = bcd;
    chain_bq  = bq;
    wait_cyc(SETTLE);
    clr_a = 1'b0; clr_b = 1'b0;
    wait_cyc(2);
  endtask

  task automatic force_nine();
    @(negedge clk) begin nine_a = 1'b1; nine_b = 1'b1; end
    wait_cyc(2);
    nine_a = 1'b0; nine_b = 1'b0;
    wait_cyc(2);
  endtask

  initial begin
    wait_cyc(3);
    check(4'd0, "R1 reset");
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);
    check(4'd0, "R1 after release");

    // R4 latency: change lands on the third rising edge after the low level
    @(negedge clk) tb_a = 1'b0;
    wait_cyc(2);
    check(4'd0, "R4 before third edge");
    wait_cyc(1);
    check(4'd1, "R4 at third edge");
    wait_cyc(SETTLE);
    tb_a = 1'b1;
    wait_cyc(SETTLE);
    check(4'd1, "R2 rising edge ignored");

    // R2 standalone divide-by-two
    set_mode(1'b0, 1'b0);
    for (int n = 1; n <= 6; n++) begin
      fall_a();
      check(4'(n % 2), "R2 toggle");
    end

    // R3 standalone divide-by-five
    set_mode(1'b0, 1'b0);
    for (int n = 1; n <= 12; n++) begin
      fall_b();
      check(4'((n % 5) << 1), "R3 quinary step");
    end

    // R5 BCD chain
    set_mode(1'b1, 1'b0);
    for (int n = 1; n <= 25; n++) begin
      fall_a();
      check(4'(n % 10), "R5 bcd");
    end
    force_nine();
    check(4'd9, "R8 preset in bcd");
    fall_a();
    check(4'd0, "R5 wrap from nine");

    // R6 bi-quinary chain
    set_mode(1'b0, 1'b1);
    for (int n = 1; n <= 25; n++) begin
      fall_b();
      check(4'((((n % 5)) << 1) | ((n / 5) % 2)), "R6 biquinary");
    end

    // R7 / R8 gated controls, standalone wiring
    set_mode(1'b0, 1'b0);
    @(negedge clk) nine_a = 1'b1;
    wait_cyc(3);
    check(4'd0, "R8 single leg a");
    nine_a = 1'b0; nine_b = 1'b1;
    wait_cyc(3);
    check(4'd0, "R8 single leg b");
    nine_b = 1'b0;
    force_nine();
    check(4'd9, "R8 both legs");
    @(negedge clk) clr_a = 1'b1;
    wait_cyc(3);
    check(4'd9, "R7 single leg a");
    clr_a = 1'b0; clr_b = 1'b1;
    wait_cyc(3);
    check(4'd9, "R7 single leg b");
    clr_a = 1'b1;
    wait_cyc(2);
    check(4'd0, "R7 both legs");

    // R9 preset over clear
    nine_a = 1'b1; nine_b = 1'b1;
    wait_cyc(2);
    check(4'd9, "R9 preset wins");
    nine_a = 1'b0; nine_b = 1'b0;
    wait_cyc(2);
    check(4'd0, "R7 clear after preset drop");

    // R10 edges during clear are dropped
    for (int k = 0; k < 3; k++) begin
      fall_a();
      fall_b();
    end
    clr_a = 1'b0; clr_b = 1'b0;
    wait_cyc(SETTLE);
    check(4'd0, "R10 edges under clear");

    // R10 edges during preset are dropped
    @(negedge clk) begin nine_a = 1'b1; nine_b = 1'b1; end
    for (int k = 0; k < 3; k++) begin
      fall_a();
      fall_b();
    end
    nine_a = 1'b0; nine_b = 1'b0;
    wait_cyc(SETTLE);
    check(4'd9, "R10 edges under preset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: out_q=%0d expected completion", out_q);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule